// File: doc/BRIEF.md
# Five-Digit BCD Display Scanner

This block time-shares one 4-bit BCD bus among five decade values. At any moment exactly one decade is selected. Its nibble appears on the data bus, and a one-hot 5-bit select vector names which decade that is. A slow scan strobe, sampled in the system clock domain, moves the selection one digit at a time. The order runs from the most significant decade down to the least significant, then wraps.

A scan-restart level forces the selection back to the ten-thousands digit. A mode flag from the counter side removes the units digit from the rotation when that decade is inhibited, so a full scan is four digits instead of five.

Each of the two output buses has its own enable. A disabled bus reads as all zeros, and its valid flag drops. The enables never affect which digit is selected.

The sequencer is a five-state machine with one state per decade:

| State | Decade | Next state on a scan step |
|---|---|---|
| `S_TTHOU` | ten-thousands (the reset state) | `S_THOU` |
| `S_THOU` | thousands | `S_HUND` |
| `S_HUND` | hundreds | `S_TENS` |
| `S_TENS` | tens | `S_UNITS`, or `S_TTHOU` when units are skipped |
| `S_UNITS` | units | `S_TTHOU` (wrap) |

A restart moves any state to `S_TTHOU`.

Top module: `digit_scan_mux`

## Requirements
- R1: While `rst_n` is low, and after it is released, the selection is the ten-thousands decade: `sel_out` = 5'b10000 (when `sel_en` is high) and `bcd_out` = `digits_bcd[19:16]`.
- R2: A scan step is a clock edge at which `scan_clk` is high and was low at the previous edge. Each step moves the selection ten-thousands → thousands → hundreds → tens → units → ten-thousands, and the new selection shows after that same edge. Holding `scan_clk` high gives only one step.
- R3: While `skip_units` is high, a step taken from the tens decade goes straight to the ten-thousands decade.
- R4: When `scan_rst` is high at a clock edge, the selection becomes ten-thousands even if a step happens at that edge. While `scan_rst` stays high, steps leave the selection at ten-thousands.
- R5: With `sel_en` high, `sel_out` is one-hot and `sel_vld` is high. Bit 0 is units, bit 1 tens, bit 2 hundreds, bit 3 thousands and bit 4 ten-thousands.
- R6: With `data_en` high, `bcd_out` equals `digits_bcd[4k+3:4k]` for selected decade k (k=0 units to k=4 ten-thousands), and `bcd_vld` is high.
- R7: With `data_en` low, `bcd_out` is 0 and `bcd_vld` is low. Steps still move the selection.
- R8: With `sel_en` low, `sel_out` is 0 and `sel_vld` is low. Steps still move the selection.
- R9: A change on `digits_bcd` reaches `bcd_out` in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_clk | input | 1 | Scan strobe level; its rising transition advances the selection |
| scan_rst | input | 1 | Scan restart; high selects the ten-thousands decade |
| skip_units | input | 1 | Units decade inhibited; shortens the scan to four digits |
| digits_bcd | input | 20 | Five BCD nibbles; nibble k is decade k, with units in bits 3:0 |
| data_en | input | 1 | Data bus enable |
| sel_en | input | 1 | Select bus enable |
| bcd_out | output | 4 | BCD value of the selected decade |
| bcd_vld | output | 1 | Data bus valid |
| sel_out | output | 5 | One-hot decade select |
| sel_vld | output | 1 | Select bus valid |

## Verification
Selection changes are due exactly one clock edge after the stimulus. That is the first edge at which a new scan level or restart level is seen, because the only registers in the path are the edge-detect flop and the state register. Enable and digit-value effects are combinational and due in the same cycle. The bench therefore drives every input on a falling edge and checks registered results on the next falling edge, with a single rising edge in between. Combinational results are checked a short delay after the input changes, with no clock edge in between.

// File: rtl/scan_mux_pkg.sv
package scan_mux_pkg;
    localparam int NUM_DIGITS = 5;
    localparam int IDX_W      = $clog2(NUM_DIGITS);

    // state value equals the decade index it selects
    typedef enum logic [IDX_W-1:0] {
        S_UNITS = 3'd0,
        S_TENS  = 3'd1,
        S_HUND  = 3'd2,
        S_THOU  = 3'd3,
        S_TTHOU = 3'd4
    } scan_state_t;
endpackage

// File: rtl/scan_edge_detect.sv
module scan_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise_out
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_in;
    end

    assign rise_out = level_in & ~level_q;
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import scan_mux_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step,
    input  logic        restart,
    input  logic        skip_low,
    output scan_state_t state_out
);
    scan_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_TTHOU;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = S_TTHOU;
        end else if (step) begin
            unique case (state_q)
                S_TTHOU: state_d = S_THOU;
                S_THOU:  state_d = S_HUND;
                S_HUND:  state_d = S_TENS;
                S_TENS:  state_d = skip_low ? S_TTHOU : S_UNITS;
                S_UNITS: state_d = S_TTHOU;
                default: state_d = S_TTHOU;
            endcase
        end
    end

    assign state_out = state_q;
endmodule

// File: rtl/digit_mux.sv
module digit_mux
    import scan_mux_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input  logic [NUM_DIGITS*DIGIT_W-1:0] digits,
    input  scan_state_t                   sel_idx,
    input  logic                          data_en,
    input  logic                          sel_en,
    output logic [DIGIT_W-1:0]            bcd_out,
    output logic                          bcd_vld,
    output logic [NUM_DIGITS-1:0]         sel_out,
    output logic                          sel_vld
);
    logic [DIGIT_W-1:0] picked;

    always_comb begin
        picked = '0;
        for (int k = 0; k < NUM_DIGITS; k++) begin
            if (sel_idx == IDX_W'(k)) picked = digits[k*DIGIT_W +: DIGIT_W];
        end
    end

    generate
        for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_sel
            assign sel_out[g] = sel_en && (sel_idx == IDX_W'(g));
        end
    endgenerate

    assign bcd_out = data_en ? picked : '0;
    assign bcd_vld = data_en;
    assign sel_vld = sel_en;
endmodule

// File: rtl/digit_scan_mux.sv
module digit_scan_mux
    import scan_mux_pkg::*;
#(
    parameter int DIGIT_W = 4,
    localparam int BUS_W  = NUM_DIGITS * DIGIT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scan_clk,
    input  logic                  scan_rst,
    input  logic                  skip_units,
    input  logic [BUS_W-1:0]      digits_bcd,
    input  logic                  data_en,
    input  logic                  sel_en,
    output logic [DIGIT_W-1:0]    bcd_out,
    output logic                  bcd_vld,
    output logic [NUM_DIGITS-1:0] sel_out,
    output logic                  sel_vld
);
    logic        scan_step;
    scan_state_t cur_state;

    scan_edge_detect u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (scan_clk),
        .rise_out (scan_step)
    );

    scan_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (scan_step),
        .restart   (scan_rst),
        .skip_low  (skip_units),
        .state_out (cur_state)
    );

    digit_mux #(.DIGIT_W(DIGIT_W)) u_mux (
        .digits  (digits_bcd),
        .sel_idx (cur_state),
        .data_en (data_en),
        .sel_en  (sel_en),
        .bcd_out (bcd_out),
        .bcd_vld (bcd_vld),
        .sel_out (sel_out),
        .sel_vld (sel_vld)
    );
endmodule

// File: rtl/digit_scan_mux_chk.sv
module digit_scan_mux_chk
    import scan_mux_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        scan_rst,
    input logic        skip_units,
    input logic        step,
    input scan_state_t st,
    input logic        data_en,
    input logic        sel_en,
    input logic [4:0]  sel_out,
    input logic [3:0]  bcd_out,
    input logic        bcd_vld,
    input logic        sel_vld
);
    a_r1_reset_sel: assert property (@(posedge clk)
        !rst_n |=> st == S_TTHOU);

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_rst && !step) |=> $stable(st));

    a_r2_descend: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_rst && step && st != S_UNITS && !(st == S_TENS && skip_units))
        |=> (3'(st) == 3'($past(st)) - 3'd1));

    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_rst && step && st == S_UNITS) |=> st == S_TTHOU);

    a_r3_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_rst && step && skip_units && st == S_TENS) |=> st == S_TTHOU);

    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        scan_rst |=> st == S_TTHOU);

    a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        sel_en |-> ($countones(sel_out) == 1 && sel_out[st] && sel_vld));

    a_r7_data_off: assert property (@(posedge clk) disable iff (!rst_n)
        !data_en |-> (bcd_out == 4'd0 && !bcd_vld));

    a_r8_sel_off: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_en |-> (sel_out == 5'd0 && !sel_vld));
endmodule

bind digit_scan_mux digit_scan_mux_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_rst   (scan_rst),
    .skip_units (skip_units),
    .step       (scan_step),
    .st         (cur_state),
    .data_en    (data_en),
    .sel_en     (sel_en),
    .sel_out    (sel_out),
    .bcd_out    (bcd_out),
    .bcd_vld    (bcd_vld),
    .sel_vld    (sel_vld)
);

// File: tb/tb_digit_scan_mux.sv
module tb_digit_scan_mux;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_clk = 1'b0;
    logic        scan_rst = 1'b0;
    logic        skip_units = 1'b0;
    logic [19:0] digits_bcd = 20'h76543;   // decade k holds k+3
    logic        data_en = 1'b1;
    logic        sel_en = 1'b1;
    logic [3:0]  bcd_out;
    logic        bcd_vld;
    logic [4:0]  sel_out;
    logic        sel_vld;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    digit_scan_mux dut (
        .clk(clk), .rst_n(rst_n), .scan_clk(scan_clk), .scan_rst(scan_rst),
        .skip_units(skip_units), .digits_bcd(digits_bcd), .data_en(data_en),
        .sel_en(sel_en), .bcd_out(bcd_out), .bcd_vld(bcd_vld),
        .sel_out(sel_out), .sel_vld(sel_vld)
    );

    // {scan_rst, skip_units, scan_clk, data_en, sel_en, exp_sel[4:0], exp_bcd[3:0]}
    localparam int NV = 31;
    localparam logic [13:0] VEC [NV] = '{
        14'b0_0_0_1_1_10000_0111,  // R1 idle at ten-thousands
        14'b0_0_1_1_1_01000_0110,  // R2 step to thousands
        14'b0_0_1_1_1_01000_0110,  // R2 held high, no second step
        14'b0_0_0_1_1_01000_0110,
        14'b0_0_1_1_1_00100_0101,  // R2 hundreds
        14'b0_0_0_1_1_00100_0101,
        14'b0_0_1_1_1_00010_0100,  // R2 tens
        14'b0_0_0_1_1_00010_0100,
        14'b0_0_1_1_1_00001_0011,  // R2 units
        14'b0_0_0_1_1_00001_0011,
        14'b0_0_1_1_1_10000_0111,  // R2 wrap
        14'b0_1_0_1_1_10000_0111,
        14'b0_1_1_1_1_01000_0110,  // R3 shortened scan
        14'b0_1_0_1_1_01000_0110,
        14'b0_1_1_1_1_00100_0101,
        14'b0_1_0_1_1_00100_0101,
        14'b0_1_1_1_1_00010_0100,
        14'b0_1_0_1_1_00010_0100,
        14'b0_1_1_1_1_10000_0111,  // R3 tens straight to ten-thousands
        14'b0_0_0_1_1_10000_0111,
        14'b0_0_1_1_1_01000_0110,
        14'b0_0_0_0_1_01000_0000,  // R7 data bus off
        14'b0_0_1_0_1_00100_0000,  // R7 selection still moves
        14'b0_0_0_1_0_00000_0101,  // R8 select bus off
        14'b0_0_1_1_0_00000_0100,  // R8 selection still moves
        14'b1_0_0_1_1_10000_0111,  // R4 restart
        14'b1_0_1_1_1_10000_0111,  // R4 step ignored while held
        14'b0_0_0_1_1_10000_0111,
        14'b0_0_1_1_1_01000_0110,
        14'b0_0_0_1_1_01000_0110,
        14'b1_0_1_1_1_10000_0111   // R4 restart beats simultaneous step
    };

    task automatic check(input string req, input logic [4:0] es, input logic [3:0] eb,
                         input logic ed, input logic esv);
        total++;
        if (sel_out !== es || bcd_out !== eb || bcd_vld !== ed || sel_vld !== esv) begin
            bad++;
            $display("FAIL %s: sel=%b bcd=%h dv=%b sv=%b expected sel=%b bcd=%h dv=%b sv=%b",
                     req, sel_out, bcd_out, bcd_vld, sel_vld, es, eb, ed, esv);
        end
    endtask

    task automatic step_once();
        @(negedge clk) scan_clk = 1'b1;
        @(negedge clk) scan_clk = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 during reset", 5'b10000, 4'h7, 1'b1, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 5'b10000, 4'h7, 1'b1, 1'b1);

        for (int i = 0; i < NV; i++) begin
            logic [13:0] v;
            v = VEC[i];
            scan_rst   = v[13];
            skip_units = v[12];
            scan_clk   = v[11];
            data_en    = v[10];
            sel_en     = v[9];
            @(negedge clk);
            check($sformatf("R2 vector %0d", i), v[8:4], v[3:0], v[10], v[9]);
        end
        scan_rst = 1'b0; scan_clk = 1'b0; skip_units = 1'b0;
        data_en = 1'b1; sel_en = 1'b1;
        @(negedge clk);

        // R6: distinct pattern, walk every position from ten-thousands down
        digits_bcd = 20'h91820;
        scan_rst = 1'b1; @(negedge clk); scan_rst = 1'b0;
        for (int k = 4; k >= 0; k--) begin
            logic [3:0] exp_n;
            exp_n = 4'((20'h91820 >> (4 * k)) & 20'hF);
            check($sformatf("R6 decade %0d", k), 5'(1 << k), exp_n, 1'b1, 1'b1);
            step_once();
        end
        check("R6 wrap", 5'b10000, 4'h9, 1'b1, 1'b1);

        // R9: digit value change visible without a clock edge
        @(negedge clk);
        #1 digits_bcd = 20'h51820;
        #1 check("R9 same-cycle update", 5'b10000, 4'h5, 1'b1, 1'b1);

        // R1: asynchronous reset mid-scan
        step_once();
        step_once();
        check("R1 pre-reset position", 5'b00100, 4'h8, 1'b1, 1'b1);
        #1 rst_n = 1'b0;
        #1 check("R1 async reset mid-scan", 5'b10000, 4'h5, 1'b1, 1'b1);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R1 release mid-scan", 5'b10000, 4'h5, 1'b1, 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule